// File: doc/BRIEF.md
# User-mode supervisor-address fault checker

This block sits beside the address-translation path of a RISC-V hart. For each instruction fetch or explicit load/store it decides, without consulting the page tables, whether a user-level access that targets the upper (supervisor) half of the virtual address space has to raise a page fault. The decision takes the same single registered cycle for every access. An attacker running in user mode therefore learns nothing about the supervisor layout from how long a fault takes to arrive.

The block also holds the two enable bits that gate the check. One bit lives in the supervisor environment-configuration CSR and the other in the hypervisor status CSR. Both are written through CSR write strobes with full-width data, and the block keeps only the bit it owns from each write. If the extension is switched off, every write stores zero. Hypervisor virtual-machine loads and stores issued from U mode are gated by the hypervisor-status bit. Every other user access is gated by the environment-configuration bit.

Top module: `ukte_fault_chk`

## Requirements
- R1: While rst_ni is low and after it is released, fault_o is 0, cause_o is 0, and both ukte_o and hukte_o are 0.
- R2: A cycle with senv_we_i high and ext_en_i high loads bit 8 of senv_wdata_i into ukte_o. All other bits of the write data have no effect.
- R3: A cycle with hstat_we_i high and ext_en_i high loads bit 24 of hstat_wdata_i into hukte_o. All other bits of the write data have no effect.
- R4: A write made while ext_en_i is low stores 0 into the targeted bit, even when the written bit is 1.
- R5: fault_o is 1 in the cycle after a request when all of these hold: req_valid_i is 1; acc_type_i is fetch (2'b01), load (2'b10) or store/AMO (2'b11); priv_i is U (2'b00); satp_mode_i is Sv39 (4'd8); vaddr_i[XLEN-1] is 1; and the selected enable bit is 1.
- R6: The cause on a fault is 12 for a fetch, 13 for a load and 15 for a store/AMO.
- R7: acc_type_i of 2'b00 (an implicit access) never faults.
- R8: priv_i of S (2'b01) or M (2'b11) never faults.
- R9: Any satp_mode_i other than Sv39 (for example Bare 4'd0 or Sv48 4'd9) never faults.
- R10: With vaddr_i[XLEN-1] at 0 there is no fault, whatever the other high address bits are.
- R11: When hyp_ls_i is 1 with priv_i U and virt_i 0, the gate is hukte_o and ukte_o is ignored.
- R12: A VU access (priv_i U, virt_i 1, hyp_ls_i 0) is gated by ukte_o and hukte_o is ignored.
- R13: fault_o and cause_o are registered one cycle after the request. In any cycle after a cycle with req_valid_i low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_en_i | input | 1 | Extension enabled; when low, enable-bit writes store 0 |
| senv_we_i | input | 1 | Write strobe, environment-configuration CSR |
| senv_wdata_i | input | XLEN | Write data, environment-configuration CSR |
| hstat_we_i | input | 1 | Write strobe, hypervisor status CSR |
| hstat_wdata_i | input | XLEN | Write data, hypervisor status CSR |
| ukte_o | output | 1 | Held user-access enable bit |
| hukte_o | output | 1 | Held hypervisor-access enable bit |
| req_valid_i | input | 1 | Access request valid |
| acc_type_i | input | 2 | 00 implicit, 01 fetch, 10 load, 11 store/AMO |
| priv_i | input | 2 | Effective privilege: 00 U, 01 S, 11 M |
| virt_i | input | 1 | Virtualization mode active |
| hyp_ls_i | input | 1 | Access comes from a hypervisor VM load/store instruction |
| satp_mode_i | input | 4 | Translation mode: 0 Bare, 8 Sv39, 9 Sv48 |
| vaddr_i | input | XLEN | Virtual address |
| fault_o | output | 1 | Page fault request, one cycle after the access |
| cause_o | output | 5 | Exception cause code for the fault |

## Verification
The bench goes after the gate selection first. If the two enable bits were swapped, a hypervisor load/store from U would fault under the user bit, and a VU access would fault under the hypervisor bit. It also checks that only the top address bit matters: a design that tested the Sv39 sign bit (bit 38) would fault on a lower-half address. Non-Sv39 modes, S and M privilege and implicit accesses must stay silent. Each access type must map to its own cause, so that a load and a store are not both reported as 13. Finally, a write made while the extension is off must clear the bit, and a design that only dropped such writes would keep a stale 1.

// File: rtl/ukte_pkg.sv
package ukte_pkg;
  localparam int CAUSE_W = 5;

  typedef enum logic [1:0] {
    ACC_IMPL  = 2'b00,
    ACC_FETCH = 2'b01,
    ACC_LOAD  = 2'b10,
    ACC_STORE = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    PRV_U = 2'b00,
    PRV_S = 2'b01,
    PRV_H = 2'b10,
    PRV_M = 2'b11
  } prv_e;

  localparam logic [3:0] MODE_BARE = 4'd0;
  localparam logic [3:0] MODE_SV39 = 4'd8;

  localparam logic [CAUSE_W-1:0] CAUSE_IPF = 5'd12;
  localparam logic [CAUSE_W-1:0] CAUSE_LPF = 5'd13;
  localparam logic [CAUSE_W-1:0] CAUSE_SPF = 5'd15;

  function automatic logic [CAUSE_W-1:0] pf_cause(acc_e t);
    case (t)
      ACC_FETCH: pf_cause = CAUSE_IPF;
      ACC_LOAD:  pf_cause = CAUSE_LPF;
      ACC_STORE: pf_cause = CAUSE_SPF;
      default:   pf_cause = '0;
    endcase
  endfunction
endpackage

// File: rtl/ukte_csr_bits.sv
module ukte_csr_bits #(
  parameter int XLEN     = 64,
  parameter int SENV_BIT = 8,
  parameter int HSTA_BIT = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_en_i,
  input  logic            senv_we_i,
  input  logic [XLEN-1:0] senv_wdata_i,
  input  logic            hstat_we_i,
  input  logic [XLEN-1:0] hstat_wdata_i,
  output logic            ukte_o,
  output logic            hukte_o
);
  logic ukte_q, hukte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ukte_q  <= 1'b0;
      hukte_q <= 1'b0;
    end else begin
      if (senv_we_i)  ukte_q  <= ext_en_i & senv_wdata_i[SENV_BIT];
      if (hstat_we_i) hukte_q <= ext_en_i & hstat_wdata_i[HSTA_BIT];
    end
  end

  assign ukte_o  = ukte_q;
  assign hukte_o = hukte_q;

  a_r4_senv_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (senv_we_i && !ext_en_i) |=> !ukte_o);
  a_r4_hstat_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hstat_we_i && !ext_en_i) |=> !hukte_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !senv_we_i |=> $stable(ukte_o));
endmodule

// File: rtl/ukte_decide.sv
module ukte_decide
  import ukte_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               req_valid_i,
  input  acc_e               acc_type_i,
  input  prv_e               priv_i,
  input  logic               virt_i,
  input  logic               hyp_ls_i,
  input  logic [3:0]         satp_mode_i,
  input  logic               sup_addr_i,
  input  logic               ukte_i,
  input  logic               hukte_i,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic explicit_acc, user_eff, gate_en;

  assign explicit_acc = (acc_type_i != ACC_IMPL);
  assign user_eff     = (priv_i == PRV_U);
  // hypervisor VM accesses from U (non-virtualized) use the hstatus gate
  assign gate_en      = (hyp_ls_i && !virt_i) ? hukte_i : ukte_i;

  always_comb begin
    fault_o = req_valid_i && explicit_acc && user_eff && gate_en &&
              (satp_mode_i == MODE_SV39) && sup_addr_i;
    cause_o = fault_o ? pf_cause(acc_type_i) : '0;
  end
endmodule

// File: rtl/ukte_fault_chk.sv
module ukte_fault_chk
  import ukte_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_en_i,
  input  logic               senv_we_i,
  input  logic [XLEN-1:0]    senv_wdata_i,
  input  logic               hstat_we_i,
  input  logic [XLEN-1:0]    hstat_wdata_i,
  output logic               ukte_o,
  output logic               hukte_o,
  input  logic               req_valid_i,
  input  logic [1:0]         acc_type_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               hyp_ls_i,
  input  logic [3:0]         satp_mode_i,
  input  logic [XLEN-1:0]    vaddr_i,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int TOP_BIT = XLEN - 1;

  logic               ukte, hukte, fault_d;
  logic [CAUSE_W-1:0] cause_d;
  logic               fault_q;
  logic [CAUSE_W-1:0] cause_q;

  ukte_csr_bits #(.XLEN(XLEN)) i_csr (
    .clk_i, .rst_ni, .ext_en_i,
    .senv_we_i, .senv_wdata_i, .hstat_we_i, .hstat_wdata_i,
    .ukte_o(ukte), .hukte_o(hukte)
  );

  ukte_decide #(.XLEN(XLEN)) i_dec (
    .req_valid_i,
    .acc_type_i (acc_e'(acc_type_i)),
    .priv_i     (prv_e'(priv_i)),
    .virt_i, .hyp_ls_i, .satp_mode_i,
    .sup_addr_i (vaddr_i[TOP_BIT]),
    .ukte_i(ukte), .hukte_i(hukte),
    .fault_o(fault_d), .cause_o(cause_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      cause_q <= '0;
    end else begin
      fault_q <= fault_d;
      cause_q <= cause_d;
    end
  end

  assign fault_o = fault_q;
  assign cause_o = cause_q;
  assign ukte_o  = ukte;
  assign hukte_o = hukte;

  a_r5_user_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($past(priv_i) == PRV_U && $past(req_valid_i)));
  a_r9_sv39_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($past(satp_mode_i) == MODE_SV39));
  a_r10_top_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(vaddr_i[TOP_BIT]));
  a_r6_cause_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && $past(acc_type_i) == ACC_FETCH) |-> (cause_o == 5'd12));
  a_r6_cause_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && $past(acc_type_i) == ACC_STORE) |-> (cause_o == 5'd15));
  a_r7_no_implicit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && acc_type_i == ACC_IMPL) |=> !fault_o);
  a_r13_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!fault_o && cause_o == '0));
endmodule

// File: tb/test_ukte_fault_chk.sv
module test_ukte_fault_chk;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            ext_en = 1'b1;
  logic            senv_we = 1'b0, hstat_we = 1'b0;
  logic [XLEN-1:0] senv_wd = '0, hstat_wd = '0;
  logic            ukte, hukte;
  logic            req = 1'b0;
  logic [1:0]      acc = 2'b00, priv = 2'b00;
  logic            virt = 1'b0, hyp = 1'b0;
  logic [3:0]      mode = 4'd0;
  logic [XLEN-1:0] va = '0;
  logic            fault;
  logic [4:0]      cause;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  ukte_fault_chk #(.XLEN(XLEN)) i_ukte_fault_chk (
    .clk_i(clk), .rst_ni(rst_ni), .ext_en_i(ext_en),
    .senv_we_i(senv_we), .senv_wdata_i(senv_wd),
    .hstat_we_i(hstat_we), .hstat_wdata_i(hstat_wd),
    .ukte_o(ukte), .hukte_o(hukte),
    .req_valid_i(req), .acc_type_i(acc), .priv_i(priv), .virt_i(virt),
    .hyp_ls_i(hyp), .satp_mode_i(mode), .vaddr_i(va),
    .fault_o(fault), .cause_o(cause)
  );

  // {req_no[3:0], ukte, hukte, acc[1:0], priv[1:0], virt, hyp, mode[3:0], va63, va38, exp_fault, exp_cause[4:0]}
  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    {4'd5,  1'b1,1'b0,2'b01,2'b00,1'b0,1'b0,4'd8,1'b1,1'b0,1'b1,5'd12}, // R5 R6 fetch
    {4'd6,  1'b1,1'b0,2'b10,2'b00,1'b0,1'b0,4'd8,1'b1,1'b0,1'b1,5'd13}, // R6 load
    {4'd6,  1'b1,1'b0,2'b11,2'b00,1'b0,1'b0,4'd8,1'b1,1'b0,1'b1,5'd15}, // R6 store
    {4'd5,  1'b0,1'b0,2'b10,2'b00,1'b0,1'b0,4'd8,1'b1,1'b0,1'b0,5'd0},  // R5 gate off
    {4'd7,  1'b1,1'b1,2'b00,2'b00,1'b0,1'b0,4'd8,1'b1,1'b0,1'b0,5'd0},  // R7 implicit
    {4'd8,  1'b1,1'b1,2'b10,2'b01,1'b0,1'b0,4'd8,1'b1,1'b0,1'b0,5'd0},  // R8 S
    {4'd8,  1'b1,1'b1,2'b11,2'b11,1'b0,1'b0,4'd8,1'b1,1'b0,1'b0,5'd0},  // R8 M
    {4'd9,  1'b1,1'b1,2'b10,2'b00,1'b0,1'b0,4'd0,1'b1,1'b0,1'b0,5'd0},  // R9 bare
    {4'd9,  1'b1,1'b1,2'b01,2'b00,1'b0,1'b0,4'd9,1'b1,1'b0,1'b0,5'd0},  // R9 sv48
    {4'd10, 1'b1,1'b1,2'b10,2'b00,1'b0,1'b0,4'd8,1'b0,1'b1,1'b0,5'd0},  // R10 bit38 only
    {4'd11, 1'b1,1'b0,2'b10,2'b00,1'b0,1'b1,4'd8,1'b1,1'b0,1'b0,5'd0},  // R11 ukte ignored
    {4'd11, 1'b0,1'b1,2'b11,2'b00,1'b0,1'b1,4'd8,1'b1,1'b0,1'b1,5'd15}, // R11 hukte gates
    {4'd12, 1'b1,1'b0,2'b01,2'b00,1'b1,1'b0,4'd8,1'b1,1'b0,1'b1,5'd12}, // R12 VU ukte
    {4'd12, 1'b0,1'b1,2'b10,2'b00,1'b1,1'b0,4'd8,1'b1,1'b0,1'b0,5'd0}   // R12 hukte ignored
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_csr(input logic en, input logic s, input logic h, input logic sb, input logic hb);
    @(negedge clk);
    ext_en   = en;
    senv_we  = s;
    hstat_we = h;
    senv_wd  = ~64'h100 | (64'(sb) << 8);
    hstat_wd = ~64'h100_0000 | (64'(hb) << 24);
    @(negedge clk);
    senv_we  = 1'b0;
    hstat_we = 1'b0;
    ext_en   = 1'b1;
  endtask

  task automatic access(input logic [1:0] a, input logic [1:0] p, input logic v,
                        input logic hy, input logic [3:0] m, input logic b63, input logic b38);
    req  = 1'b1; acc = a; priv = p; virt = v; hyp = hy; mode = m;
    va   = 64'h0000_0000_1234_5000;
    va[63] = b63;
    va[38] = b38;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset
    #12;
    chk("R1 fault", 8'(fault), 8'd0);
    chk("R1 cause", 8'(cause), 8'd0);
    chk("R1 ukte", 8'(ukte), 8'd0);
    chk("R1 hukte", 8'(hukte), 8'd0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 fault after release", 8'(fault), 8'd0);

    // R2 / R3: only the owned bit is kept
    wr_csr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 other bits ignored", 8'(ukte), 8'd0);
    wr_csr(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R2 bit8 set", 8'(ukte), 8'd1);
    chk("R3 untouched by senv write", 8'(hukte), 8'd0);
    wr_csr(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 other bits ignored", 8'(hukte), 8'd0);
    wr_csr(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R3 bit24 set", 8'(hukte), 8'd1);

    // R4 masked writes clear the bit
    wr_csr(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R4 ukte masked", 8'(ukte), 8'd0);
    chk("R4 hukte masked", 8'(hukte), 8'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [23:0] e;
      string tag;
      e = VEC[i];
      wr_csr(1'b1, 1'b1, 1'b1, e[19], e[18]);
      access(e[17:16], e[15:14], e[13], e[12], e[11:8], e[7], e[6]);
      tag = $sformatf("R%0d vec %0d fault", e[23:20], i);
      chk(tag, 8'(fault), 8'(e[5]));
      tag = $sformatf("R%0d vec %0d cause", e[23:20], i);
      chk(tag, 8'(cause), 8'(e[4:0]));
    end

    // R13: faulting setup without valid; output clears after request drops
    wr_csr(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    access(2'b10, 2'b00, 1'b0, 1'b0, 4'd8, 1'b1, 1'b0);
    chk("R13 registered fault", 8'(fault), 8'd1);
    @(negedge clk);
    chk("R13 fault clears", 8'(fault), 8'd0);
    chk("R13 cause clears", 8'(cause), 8'd0);
    req = 1'b0; acc = 2'b11; mode = 4'd8; va[63] = 1'b1;
    @(negedge clk);
    chk("R13 no valid no fault", 8'(fault), 8'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule